// File: doc/BRIEF.md
# Event Driven Timestamp Decoder

This block turns a stream of received 8-bit event codes into an absolute time in two parts: a whole-seconds value and a sub-second tick count. Once per second the sender transmits the seconds value serially, one event code per bit, first bit as most significant. A final load code then commits the assembled word to the seconds register and restarts the sub-second count, so both halves change together.

The sub-second counter advances on a tick whose source is chosen at run time. It can be a divided version of the event clock, rising edges of one asynchronous distributed-bus bit brought in through a synchroniser, or a dedicated increment event code. A one-cycle capture request copies both halves into a pair of holding registers, so software sees a consistent time pair even while the live values keep moving.

Top module: `evt_timestamp`

## Requirements
- R1: While reset is low and on the first cycle after it, `sec_now`, `ts_now`, `sec_hold` and `ts_hold` all read zero.
- R2: An accepted code 0x70 shifts a 0, and code 0x71 shifts a 1, into a 32-bit assembly register from the least significant end. After 32 such codes, code 0x7D makes `sec_now` equal the 32 bits, the first one sent being bit 31.
- R3: `sec_now` changes only on an accepted code 0x7D. Bit codes and all other codes, including a code presented with `evt_valid` low, leave it and the assembled bits unchanged.
- R4: An accepted code 0x7D sets `ts_now` to zero at that clock edge and restarts the divider, even when a tick falls on the same edge.
- R5: With `tick_sel` = 0 the counter advances once every D cycles, D being `presc_div`; a value of 0 acts as 1. After a load at edge E, `ts_now` equals floor(n/D) n edges later.
- R6: With `tick_sel` = 1 each rising edge of `dbus_tick` advances the counter exactly once. The counter changes on the third clock edge after the input rises. Holding the input high gives no further ticks.
- R7: With `tick_sel` = 2 each accepted code 0x7C advances the counter at that same edge. Other codes and a 0x7C with `evt_valid` low leave it alone.
- R8: With `tick_sel` = 3 the counter holds its value, except for a load.
- R9: A high `hold_req` at a clock edge copies the values `sec_now` and `ts_now` had just before that edge into `sec_hold` and `ts_hold`. Without a request, the holding registers keep their contents.
- R10: When `hold_req` and an accepted code 0x7D share an edge, the holding registers receive the pre-load seconds and count. The live registers take the new seconds and zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A received event code is present this cycle |
| evt_code | input | 8 | Received event code |
| hold_req | input | 1 | Capture request (mapped bit 14) |
| tick_sel | input | 2 | Tick source: 0 divider, 1 bus bit, 2 code 0x7C, 3 none |
| presc_div | input | 16 | Divider ratio for tick source 0 |
| dbus_tick | input | 1 | Asynchronous distributed-bus bit used as tick source 1 |
| sec_now | output | 32 | Live seconds register |
| ts_now | output | 32 | Live sub-second counter |
| sec_hold | output | 32 | Captured seconds |
| ts_hold | output | 32 | Captured sub-second count |

## Verification
The hardest case to reach from the ports is a capture request on the very edge that commits a new seconds word. At that edge the holding registers and the live registers must take values from opposite sides of the same edge. The bench first builds a known time and then shifts in a different 32-bit word. It raises the capture request together with the 0x7D code, so both halves can be compared against the old and the new values at once. The divider phase after a load is the other delicate point. A sweep over the ratios 0 to 6 and 0 to 7 elapsed cycles per ratio checks every position of the count against floor division.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic [1:0] {
        TCK_DIVIDER = 2'd0,
        TCK_BUSBIT  = 2'd1,
        TCK_EVENT   = 2'd2,
        TCK_NONE    = 2'd3
    } tick_src_e;

    localparam logic [7:0] CODE_SHIFT0 = 8'h70;
    localparam logic [7:0] CODE_SHIFT1 = 8'h71;
    localparam logic [7:0] CODE_INC    = 8'h7C;
    localparam logic [7:0] CODE_LOAD   = 8'h7D;

endpackage

// File: rtl/ts_sec_assembler.sv
module ts_sec_assembler #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_val,
    input  logic             load,
    output logic [SEC_W-1:0] shift_q,
    output logic [SEC_W-1:0] sec_q
);

    typedef struct packed {
        logic [SEC_W-1:0] shift;
        logic [SEC_W-1:0] sec;
    } asm_st_t;

    asm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_valid) begin
            st_d.shift = {st_q.shift[SEC_W-2:0], bit_val};
        end
        if (load) begin
            st_d.sec = st_q.shift;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_q = st_q.shift;
    assign sec_q   = st_q.sec;

endmodule

// File: rtl/ts_tick_gen.sv
module ts_tick_gen
    import ts_pkg::*;
#(
    parameter int PRESC_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         src,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic               restart,
    input  logic               dbus_in,
    input  logic               inc_evt,
    output logic               tick
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [PRESC_W-1:0]     pcnt;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } tg_st_t;

    tg_st_t st_d, st_q;

    logic [SYNC_STAGES-1:0] sync_next;
    logic [PRESC_W-1:0]     div_last;
    logic                   div_tick;
    logic                   bus_edge;
    tick_src_e              src_e;

    // synchroniser chain: stage 0 samples the pin, later stages follow
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            assign sync_next[g] = dbus_in;
        end else begin : g_next
            assign sync_next[g] = st_q.sync[g-1];
        end
    end

    always_comb begin
        src_e    = tick_src_e'(src);
        div_last = (presc_div == '0) ? '0 : presc_div - 1'b1;
        div_tick = (st_q.pcnt >= div_last);
        bus_edge = st_q.sync[LAST] & ~st_q.prev;

        st_d      = st_q;
        st_d.sync = sync_next;
        st_d.prev = st_q.sync[LAST];
        if (restart || div_tick) begin
            st_d.pcnt = '0;
        end else begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end

        case (src_e)
            TCK_DIVIDER: tick = div_tick;
            TCK_BUSBIT:  tick = bus_edge;
            TCK_EVENT:   tick = inc_evt;
            default:     tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evt_timestamp.sv
module evt_timestamp
    import ts_pkg::*;
#(
    parameter int SEC_W       = 32,
    parameter int TS_W        = 32,
    parameter int PRESC_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [7:0]         evt_code,
    input  logic               hold_req,
    input  logic [1:0]         tick_sel,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic               dbus_tick,
    output logic [SEC_W-1:0]   sec_now,
    output logic [TS_W-1:0]    ts_now,
    output logic [SEC_W-1:0]   sec_hold,
    output logic [TS_W-1:0]    ts_hold
);

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [SEC_W-1:0] sec_l;
        logic [TS_W-1:0]  ts_l;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             is_bit, is_load, is_inc, tick;
    logic [SEC_W-1:0] sec_shift;

    always_comb begin
        is_bit  = evt_valid && ((evt_code == CODE_SHIFT0) || (evt_code == CODE_SHIFT1));
        is_load = evt_valid && (evt_code == CODE_LOAD);
        is_inc  = evt_valid && (evt_code == CODE_INC);
    end

    ts_sec_assembler #(.SEC_W(SEC_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (is_bit),
        .bit_val   (evt_code == CODE_SHIFT1),
        .load      (is_load),
        .shift_q   (sec_shift),
        .sec_q     (sec_now)
    );

    ts_tick_gen #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (tick_sel),
        .presc_div (presc_div),
        .restart   (is_load),
        .dbus_in   (dbus_tick),
        .inc_evt   (is_inc),
        .tick      (tick)
    );

    always_comb begin
        st_d = st_q;
        if (is_load) begin
            st_d.ts = '0;
        end else if (tick) begin
            st_d.ts = st_q.ts + 1'b1;
        end
        // capture uses register outputs, i.e. values before this edge
        if (hold_req) begin
            st_d.sec_l = sec_now;
            st_d.ts_l  = st_q.ts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ts_now   = st_q.ts;
    assign sec_hold = st_q.sec_l;
    assign ts_hold  = st_q.ts_l;

endmodule

module evt_timestamp_chk #(
    parameter int SEC_W = 32,
    parameter int TS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic [7:0]       evt_code,
    input logic             hold_req,
    input logic [1:0]       tick_sel,
    input logic [SEC_W-1:0] sec_shift,
    input logic [SEC_W-1:0] sec_now,
    input logic [TS_W-1:0]  ts_now,
    input logic [SEC_W-1:0] sec_hold,
    input logic [TS_W-1:0]  ts_hold
);

    logic ld;
    assign ld = evt_valid && (evt_code == 8'h7D);

    // R2
    shift_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 8'h71) |=>
            (sec_shift == {$past(sec_shift[SEC_W-2:0]), 1'b1}));

    // R2
    shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 8'h70) |=>
            (sec_shift == {$past(sec_shift[SEC_W-2:0]), 1'b0}));

    // R3
    sec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(sec_now));

    // R4
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (ts_now == '0) && (sec_now == $past(sec_shift)));

    // R5
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (ts_now == $past(ts_now)) || (ts_now == $past(ts_now) + 1'b1));

    // R8
    ts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && tick_sel == 2'd3) |=> $stable(ts_now));

    // R9
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> (sec_hold == $past(sec_now)) && (ts_hold == $past(ts_now)));

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |=> $stable(sec_hold) && $stable(ts_hold));

endmodule

bind evt_timestamp evt_timestamp_chk #(.SEC_W(SEC_W), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .hold_req  (hold_req),
    .tick_sel  (tick_sel),
    .sec_shift (sec_shift),
    .sec_now   (sec_now),
    .ts_now    (ts_now),
    .sec_hold  (sec_hold),
    .ts_hold   (ts_hold)
);

// File: tb/evt_timestamp_tb.sv
module evt_timestamp_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid;
    logic [7:0]  evt_code;
    logic        hold_req;
    logic [1:0]  tick_sel;
    logic [15:0] presc_div;
    logic        dbus_tick;
    logic [31:0] sec_now, ts_now, sec_hold, ts_hold;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    evt_timestamp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .hold_req  (hold_req),
        .tick_sel  (tick_sel),
        .presc_div (presc_div),
        .dbus_tick (dbus_tick),
        .sec_now   (sec_now),
        .ts_now    (ts_now),
        .sec_hold  (sec_hold),
        .ts_hold   (ts_hold)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c, input logic lat);
        evt_valid = 1'b1;
        evt_code  = c;
        hold_req  = lat;
        @(negedge clk);
        evt_valid = 1'b0;
        hold_req  = 1'b0;
        evt_code  = 8'h00;
    endtask

    // shifts 32 bits, first bit sent is bit 31
    task automatic shift_word(input logic [31:0] v, input logic noise);
        for (int i = 31; i >= 0; i--) begin
            send(v[i] ? 8'h71 : 8'h70, 1'b0);
            if (noise && i == 16) begin
                send(8'h55, 1'b0);
                evt_valid = 1'b0;
                evt_code  = 8'h71;
                @(negedge clk);
                evt_code  = 8'h00;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] vals [4];
        logic [31:0] old_sec;
        int          exp_ts;
        vals[0] = 32'hA5C3_0F81;
        vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFE;
        vals[3] = 32'h8000_0000;

        rst_n = 1'b0; evt_valid = 1'b0; evt_code = 8'h00; hold_req = 1'b0;
        tick_sel = 2'd3; presc_div = 16'd0; dbus_tick = 1'b0;
        idle(3);
        // R1 during reset
        chk("R1 sec_now", sec_now, 32'h0);
        chk("R1 ts_now", ts_now, 32'h0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 sec_hold", sec_hold, 32'h0);
        chk("R1 ts_hold", ts_hold, 32'h0);
        chk("R1 ts_now after", ts_now, 32'h0);

        // R2 / R3 seconds assembly
        old_sec = 32'h0;
        for (int k = 0; k < 4; k++) begin
            shift_word(vals[k], k == 0);
            chk("R3 sec before load", sec_now, old_sec);
            send(8'h7D, 1'b0);
            chk("R2 sec after load", sec_now, vals[k]);
            old_sec = vals[k];
        end

        // R5 / R4 divider sweep
        tick_sel = 2'd0;
        for (int d = 0; d <= 6; d++) begin
            for (int n = 0; n <= 7; n++) begin
                presc_div = 16'(d);
                idle(n + 2);
                send(8'h7D, 1'b0);
                if (n == 0) chk("R4 load clears ts", ts_now, 32'h0);
                idle(n);
                chk("R5 divided count", ts_now, 32'(n / ((d == 0) ? 1 : d)));
            end
        end

        // R7 increment code
        tick_sel = 2'd2;
        send(8'h7D, 1'b0);
        exp_ts = 0;
        for (int i = 0; i < 6; i++) begin
            send(8'h7C, 1'b0);
            exp_ts++;
            chk("R7 inc code", ts_now, 32'(exp_ts));
            send(8'h42, 1'b0);
            evt_code = 8'h7C;
            idle(i);
            evt_code = 8'h00;
            chk("R7 ignored codes", ts_now, 32'(exp_ts));
        end

        // R6 bus-bit edges
        tick_sel = 2'd1;
        send(8'h7D, 1'b0);
        dbus_tick = 1'b1;
        idle(2);
        chk("R6 not yet", ts_now, 32'h0);
        idle(1);
        chk("R6 third edge", ts_now, 32'h1);
        idle(6);
        chk("R6 level no retick", ts_now, 32'h1);
        dbus_tick = 1'b0;
        idle(3);
        for (int p = 0; p < 4; p++) begin
            dbus_tick = 1'b1;
            idle(1 + p);
            dbus_tick = 1'b0;
            idle(3);
        end
        idle(3);
        chk("R6 pulse count", ts_now, 32'd5);

        // R8 no source
        tick_sel = 2'd3;
        presc_div = 16'd1;
        send(8'h7C, 1'b0);
        dbus_tick = 1'b1;
        idle(8);
        dbus_tick = 1'b0;
        chk("R8 hold", ts_now, 32'd5);

        // R9 capture
        tick_sel = 2'd2;
        send(8'h7D, 1'b0);
        repeat (3) send(8'h7C, 1'b0);
        send(8'h00, 1'b1);
        chk("R9 sec captured", sec_hold, vals[3]);
        chk("R9 ts captured", ts_hold, 32'd3);
        repeat (2) send(8'h7C, 1'b0);
        chk("R9 hold kept", ts_hold, 32'd3);
        send(8'h7C, 1'b1);
        chk("R9 pre-edge ts", ts_hold, 32'd5);
        chk("R9 live ts", ts_now, 32'd6);

        // R10 capture on load edge
        shift_word(32'h1234_5678, 1'b0);
        send(8'h7D, 1'b1);
        chk("R10 hold old sec", sec_hold, vals[3]);
        chk("R10 hold old ts", ts_hold, 32'd6);
        chk("R10 live new sec", sec_now, 32'h1234_5678);
        chk("R10 live ts zero", ts_now, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule